// File: doc/BRIEF.md
# Bus Address/Data Match Comparator Bank

This block watches two processor buses and reports bus cycles that meet programmed conditions. One bus belongs to the main CPU and the other to a coprocessor. Four comparators, numbered 0 to 3, each pick one of the two buses. Each comparator can require a given transfer direction and a given access size. Comparators 0 and 2 also compare the 16-bit data word under a per-bit mask. Comparators 1 and 3 compare the address only. Each comparator drives its own bit of a match vector for one cycle. A trigger sequencer reads these bits as trigger inputs.

The comparators work in pairs: 0 with 1, and 2 with 3. The lower comparator of a pair (the leader) can switch the pair into a window mode. In that mode the leader's address is the lower bound and the partner's address is the upper bound. The pair then matches on addresses inside the bounds or outside them. In a window mode, the result appears on the leader's bit only.

A debug-monitor inhibit input silences every comparator that watches the CPU bus. The registers can still be written and read while it is high. The configuration is set through a small word-wide register port with combinational read data.

Top module: `bus_match_bank`

## Requirements
- R1: After reset, every register reads zero and no match bit is set.
- R2: Registers are selected by reg_addr = {comparator[1:0], field[1:0]}, where field 0 is control, 1 is address, 2 is data and 3 is mask. Control bits are: [0] enable, [1] bus select (1 = coprocessor), [2] direction check, [3] direction value (1 = read), [4] size check, [5] size value (1 = word), [7:6] mode (0 exact, 1 inside, 2 outside, 3 treated as exact). For comparators 1 and 3, the data and mask fields and control bits [7:6] read zero and ignore writes.
- R3: A comparator in exact mode with a data field (0 or 2) matches when the address is equal and the data bits under set mask bits are equal. Data bits whose mask bit is clear are ignored.
- R4: Comparators 1 and 3 match on address equality alone, whatever the data value.
- R5: A comparator whose enable bit is clear never sets its match bit.
- R6: Each comparator watches only the bus that its bus-select bit chooses.
- R7: When direction check is set, a match requires the bus read flag to equal the direction value. When size check is set, a match requires the bus word flag to equal the size value.
- R8: In inside mode, the leader's bit is set when min <= address <= max, with both bounds included. In either window mode the partner's bit stays clear, and the data is not compared.
- R9: In outside mode, the leader's bit is set when address < min or address > max.
- R10: A match bit is set in the cycle after a valid qualifying bus cycle, once for each such cycle. A cycle without valid never matches.
- R11: While cpu_inhibit is high, comparators watching the CPU bus do not match, and comparators watching the coprocessor bus still do. Register writes and reads keep working while cpu_inhibit is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register select {comparator, field} |
| reg_wdata | input | ADDR_W | Register write data |
| reg_rdata | output | ADDR_W | Register read data (combinational) |
| cpu_valid | input | 1 | CPU bus cycle is not idle |
| cpu_addr | input | ADDR_W | CPU bus address |
| cpu_data | input | DATA_W | CPU bus data |
| cpu_rd | input | 1 | CPU cycle is a read |
| cpu_word | input | 1 | CPU cycle is a word access |
| cop_valid | input | 1 | Coprocessor bus cycle is not idle |
| cop_addr | input | ADDR_W | Coprocessor bus address |
| cop_data | input | DATA_W | Coprocessor bus data |
| cop_rd | input | 1 | Coprocessor cycle is a read |
| cop_word | input | 1 | Coprocessor cycle is a word access |
| cpu_inhibit | input | 1 | Debug monitor active; mutes comparators watching the CPU bus |
| match_o | output | 4 | Registered one-cycle match bit per comparator |

## Verification
The hardest cases to reach are the window-mode corners. There the partner comparator would match on its own address, yet its bit must stay clear. The bounds themselves must also fall on the right side of the window. The stimulus first enables the partner with its upper-bound address in exact mode. It then switches the leader into inside mode and then outside mode. It drives addresses one below the lower bound, on each bound, and one above the upper bound, and expects the partner's bit to stay low throughout. The inhibit case is reached by holding cpu_inhibit high. During that time the bench drives a CPU cycle and a coprocessor cycle that would both match, and it also writes a register and reads it back.

// File: rtl/bmb_pkg.sv
package bmb_pkg;

   typedef enum logic [1:0] {
      MODE_EXACT   = 2'd0,
      MODE_INSIDE  = 2'd1,
      MODE_OUTSIDE = 2'd2,
      MODE_RSVD    = 2'd3
   } cmp_mode_e;

   // packed: mode occupies bits [7:6], en is bit 0
   typedef struct packed {
      cmp_mode_e mode;
      logic      size_word;
      logic      size_chk;
      logic      dir_rd;
      logic      dir_chk;
      logic      bus_cop;
      logic      en;
   } cmp_ctrl_t;

   localparam logic [1:0] FLD_CTRL = 2'd0;
   localparam logic [1:0] FLD_ADDR = 2'd1;
   localparam logic [1:0] FLD_DATA = 2'd2;
   localparam logic [1:0] FLD_MASK = 2'd3;

   localparam int NUM_CMP  = 4;
   localparam int NUM_PAIR = NUM_CMP / 2;

endpackage

// File: rtl/bmb_cmp_regs.sv
module bmb_cmp_regs
   import bmb_pkg::*;
#(
   parameter int ADDR_W   = 24,
   parameter int DATA_W   = 16,
   parameter bit HAS_DATA = 1'b1,
   parameter bit HAS_MODE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        fld,
   input  logic [ADDR_W-1:0] wdata,
   output cmp_ctrl_t         ctrl,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] data_q,
   output logic [DATA_W-1:0] mask_q,
   output logic [ADDR_W-1:0] rdata
);

   localparam int CTRL_W = $bits(cmp_ctrl_t);
   localparam int LOW_W  = CTRL_W - 2;

   logic wr_ctrl, wr_addr, wr_data, wr_mask;

   assign wr_ctrl = wr_en && (fld == FLD_CTRL);
   assign wr_addr = wr_en && (fld == FLD_ADDR);
   assign wr_data = wr_en && (fld == FLD_DATA);
   assign wr_mask = wr_en && (fld == FLD_MASK);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       addr_q <= '0;
      else if (wr_addr) addr_q <= wdata;
   end

   generate
      if (HAS_MODE) begin : g_mode
         logic [CTRL_W-1:0] ctrl_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       ctrl_q <= '0;
            else if (wr_ctrl) ctrl_q <= wdata[CTRL_W-1:0];
         end
         assign ctrl = cmp_ctrl_t'(ctrl_q);
      end else begin : g_nomode
         logic [LOW_W-1:0] ctrl_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       ctrl_q <= '0;
            else if (wr_ctrl) ctrl_q <= wdata[LOW_W-1:0];
         end
         assign ctrl = cmp_ctrl_t'({2'b00, ctrl_q});
      end

      if (HAS_DATA) begin : g_data
         logic [DATA_W-1:0] data_r, mask_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               data_r <= '0;
               mask_r <= '0;
            end else begin
               if (wr_data) data_r <= wdata[DATA_W-1:0];
               if (wr_mask) mask_r <= wdata[DATA_W-1:0];
            end
         end
         assign data_q = data_r;
         assign mask_q = mask_r;
      end else begin : g_nodata
         // all-zero mask makes the data comparison a don't-care
         assign data_q = '0;
         assign mask_q = '0;
      end
   endgenerate

   always_comb begin
      rdata = '0;
      unique case (fld)
         FLD_CTRL: rdata[CTRL_W-1:0] = ctrl;
         FLD_ADDR: rdata = addr_q;
         FLD_DATA: rdata[DATA_W-1:0] = data_q;
         FLD_MASK: rdata[DATA_W-1:0] = mask_q;
         default:  rdata = '0;
      endcase
   end

endmodule

// File: rtl/bmb_cmp_qual.sv
module bmb_cmp_qual
   import bmb_pkg::*;
#(
   parameter int ADDR_W = 24,
   parameter int DATA_W = 16
) (
   input  cmp_ctrl_t         ctrl,
   input  logic [ADDR_W-1:0] addr_q,
   input  logic [DATA_W-1:0] data_q,
   input  logic [DATA_W-1:0] mask_q,
   input  logic              cpu_valid,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_data,
   input  logic              cpu_rd,
   input  logic              cpu_word,
   input  logic              cop_valid,
   input  logic [ADDR_W-1:0] cop_addr,
   input  logic [DATA_W-1:0] cop_data,
   input  logic              cop_rd,
   input  logic              cop_word,
   input  logic              cpu_inhibit,
   output logic              ok,
   output logic              eq
);

   logic              s_valid, s_rd, s_word;
   logic [ADDR_W-1:0] s_addr;
   logic [DATA_W-1:0] s_data;
   logic              muted, dir_ok, size_ok;

   always_comb begin
      if (ctrl.bus_cop) begin
         s_valid = cop_valid;
         s_addr  = cop_addr;
         s_data  = cop_data;
         s_rd    = cop_rd;
         s_word  = cop_word;
      end else begin
         s_valid = cpu_valid;
         s_addr  = cpu_addr;
         s_data  = cpu_data;
         s_rd    = cpu_rd;
         s_word  = cpu_word;
      end
   end

   assign muted   = cpu_inhibit && !ctrl.bus_cop;
   assign dir_ok  = !ctrl.dir_chk  || (s_rd   == ctrl.dir_rd);
   assign size_ok = !ctrl.size_chk || (s_word == ctrl.size_word);

   assign ok = ctrl.en && s_valid && !muted && dir_ok && size_ok;
   assign eq = (s_addr == addr_q) && (((s_data ^ data_q) & mask_q) == '0);

endmodule

// File: rtl/bmb_pair.sv
module bmb_pair
   import bmb_pkg::*;
#(
   parameter int ADDR_W = 24
) (
   input  cmp_mode_e         mode,
   input  logic              ok_lo,
   input  logic              eq_lo,
   input  logic              ok_hi,
   input  logic              eq_hi,
   input  logic [ADDR_W-1:0] win_addr,
   input  logic [ADDR_W-1:0] min_addr,
   input  logic [ADDR_W-1:0] max_addr,
   output logic              hit_lo,
   output logic              hit_hi
);

   logic below, above, windowed;

   assign below    = win_addr < min_addr;
   assign above    = win_addr > max_addr;
   assign windowed = (mode == MODE_INSIDE) || (mode == MODE_OUTSIDE);

   always_comb begin
      unique case (mode)
         MODE_INSIDE:  hit_lo = ok_lo && !below && !above;
         MODE_OUTSIDE: hit_lo = ok_lo && (below || above);
         default:      hit_lo = ok_lo && eq_lo;
      endcase
   end

   assign hit_hi = ok_hi && eq_hi && !windowed;

endmodule

// File: rtl/bus_match_bank.sv
module bus_match_bank
   import bmb_pkg::*;
#(
   parameter int ADDR_W = 24,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [3:0]        reg_addr,
   input  logic [ADDR_W-1:0] reg_wdata,
   output logic [ADDR_W-1:0] reg_rdata,
   input  logic              cpu_valid,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_data,
   input  logic              cpu_rd,
   input  logic              cpu_word,
   input  logic              cop_valid,
   input  logic [ADDR_W-1:0] cop_addr,
   input  logic [DATA_W-1:0] cop_data,
   input  logic              cop_rd,
   input  logic              cop_word,
   input  logic              cpu_inhibit,
   output logic [3:0]        match_o
);

   localparam int CTRL_W = $bits(cmp_ctrl_t);

   generate
      if (DATA_W < 1 || ADDR_W < CTRL_W || ADDR_W < DATA_W) begin : g_bad_param
         $error("bus_match_bank: ADDR_W must be >= DATA_W and >= control width");
      end
   endgenerate

   cmp_ctrl_t         ctrl_a  [NUM_CMP];
   logic [ADDR_W-1:0] addr_a  [NUM_CMP];
   logic [DATA_W-1:0] data_a  [NUM_CMP];
   logic [DATA_W-1:0] mask_a  [NUM_CMP];
   logic [ADDR_W-1:0] rdata_a [NUM_CMP];
   logic [NUM_CMP-1:0] ok_v, eq_v, hit_v;
   logic [NUM_CMP-1:0] match_q;

   genvar gi;
   generate
      for (gi = 0; gi < NUM_CMP; gi++) begin : g_cmp
         localparam bit LEADER = (gi % 2) == 0;
         logic sel;
         assign sel = reg_wr && (reg_addr[3:2] == 2'(gi));

         bmb_cmp_regs #(
            .ADDR_W  (ADDR_W),
            .DATA_W  (DATA_W),
            .HAS_DATA(LEADER),
            .HAS_MODE(LEADER)
         ) u_regs (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (sel),
            .fld   (reg_addr[1:0]),
            .wdata (reg_wdata),
            .ctrl  (ctrl_a[gi]),
            .addr_q(addr_a[gi]),
            .data_q(data_a[gi]),
            .mask_q(mask_a[gi]),
            .rdata (rdata_a[gi])
         );

         bmb_cmp_qual #(
            .ADDR_W(ADDR_W),
            .DATA_W(DATA_W)
         ) u_qual (
            .ctrl       (ctrl_a[gi]),
            .addr_q     (addr_a[gi]),
            .data_q     (data_a[gi]),
            .mask_q     (mask_a[gi]),
            .cpu_valid  (cpu_valid),
            .cpu_addr   (cpu_addr),
            .cpu_data   (cpu_data),
            .cpu_rd     (cpu_rd),
            .cpu_word   (cpu_word),
            .cop_valid  (cop_valid),
            .cop_addr   (cop_addr),
            .cop_data   (cop_data),
            .cop_rd     (cop_rd),
            .cop_word   (cop_word),
            .cpu_inhibit(cpu_inhibit),
            .ok         (ok_v[gi]),
            .eq         (eq_v[gi])
         );

         // R5
         en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
            match_q[gi] |-> $past(ctrl_a[gi].en));

         // R10
         idle_no_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
            match_q[gi] |-> $past(cpu_valid || cop_valid));

         // R11
         inhibit_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(cpu_inhibit && !ctrl_a[gi].bus_cop) |-> !match_q[gi]);
      end

      for (gi = 0; gi < NUM_PAIR; gi++) begin : g_pair
         localparam int LO = 2 * gi;
         localparam int HI = 2 * gi + 1;
         logic [ADDR_W-1:0] win_addr;

         assign win_addr = ctrl_a[LO].bus_cop ? cop_addr : cpu_addr;

         bmb_pair #(.ADDR_W(ADDR_W)) u_pair (
            .mode    (ctrl_a[LO].mode),
            .ok_lo   (ok_v[LO]),
            .eq_lo   (eq_v[LO]),
            .ok_hi   (ok_v[HI]),
            .eq_hi   (eq_v[HI]),
            .win_addr(win_addr),
            .min_addr(addr_a[LO]),
            .max_addr(addr_a[HI]),
            .hit_lo  (hit_v[LO]),
            .hit_hi  (hit_v[HI])
         );

         // R8
         partner_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past((ctrl_a[LO].mode == MODE_INSIDE) || (ctrl_a[LO].mode == MODE_OUTSIDE))
            |-> !match_q[HI]);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) match_q <= '0;
      else        match_q <= hit_v;
   end

   assign match_o   = match_q;
   assign reg_rdata = rdata_a[reg_addr[3:2]];

endmodule

// File: tb/tb_bus_match_bank.sv
module tb_bus_match_bank;

   localparam int AW = 24;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0;
   logic [3:0]    reg_addr = '0;
   logic [AW-1:0] reg_wdata = '0;
   logic [AW-1:0] reg_rdata;
   logic          cpu_valid = 1'b0, cpu_rd = 1'b0, cpu_word = 1'b0;
   logic [AW-1:0] cpu_addr = '0;
   logic [DW-1:0] cpu_data = '0;
   logic          cop_valid = 1'b0, cop_rd = 1'b0, cop_word = 1'b0;
   logic [AW-1:0] cop_addr = '0;
   logic [DW-1:0] cop_data = '0;
   logic          cpu_inhibit = 1'b0;
   logic [3:0]    match_o;

   int n_run = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   logic [3:0] exp_q[$];
   string      tag_q[$];

   always #4 clk = ~clk;

   bus_match_bank #(.ADDR_W(AW), .DATA_W(DW)) dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .cpu_valid(cpu_valid), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
      .cpu_rd(cpu_rd), .cpu_word(cpu_word),
      .cop_valid(cop_valid), .cop_addr(cop_addr), .cop_data(cop_data),
      .cop_rd(cop_rd), .cop_word(cop_word),
      .cpu_inhibit(cpu_inhibit), .match_o(match_o)
   );

   // monitor: the item driven before this edge is registered at the edge
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (exp_q.size() > 0) begin
            logic [3:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_run++;
            if (match_o !== e) begin
               n_fail++;
               $display("FAIL %s: match_o actual %b expected %b", t, match_o, e);
            end
         end
      end
   end

   task automatic idle_bus();
      cpu_valid = 1'b0;
      cop_valid = 1'b0;
   endtask

   task automatic wr(input logic [1:0] idx, input logic [1:0] fld, input logic [AW-1:0] v);
      @(negedge clk);
      idle_bus();
      reg_wr = 1'b1;
      reg_addr = {idx, fld};
      reg_wdata = v;
      @(posedge clk);
      #1 reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] idx, input logic [1:0] fld,
                     input logic [AW-1:0] e, input string t);
      @(negedge clk);
      idle_bus();
      reg_addr = {idx, fld};
      #1;
      n_run++;
      if (reg_rdata !== e) begin
         n_fail++;
         $display("FAIL %s: reg_rdata actual %h expected %h", t, reg_rdata, e);
      end
   endtask

   // driver: one bus cycle on the chosen bus, expected match vector queued
   task automatic bus(input bit cop, input bit vld, input logic [AW-1:0] a,
                      input logic [DW-1:0] d, input bit r, input bit w,
                      input logic [3:0] e, input string t);
      @(negedge clk);
      idle_bus();
      if (cop) begin
         cop_valid = vld; cop_addr = a; cop_data = d; cop_rd = r; cop_word = w;
      end else begin
         cpu_valid = vld; cpu_addr = a; cpu_data = d; cpu_rd = r; cpu_word = w;
      end
      exp_q.push_back(e);
      tag_q.push_back(t);
   endtask

   task automatic disable_all();
      for (int i = 0; i < 4; i++) wr(2'(i), 2'd0, '0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      bus(1'b0, 1'b0, 24'h0, 16'h0, 1'b0, 1'b0, 4'b0000, "R1 idle after reset");
      rd(2'd0, 2'd0, '0, "R1 ctrl0 reset");
      rd(2'd2, 2'd3, '0, "R1 mask2 reset");
      rd(2'd3, 2'd1, '0, "R1 addr3 reset");

      // R2 register map
      wr(2'd0, 2'd1, 24'h123456);
      wr(2'd0, 2'd2, 24'h00BEEF);
      wr(2'd0, 2'd3, 24'h00FF00);
      wr(2'd0, 2'd0, 24'h0000C1);
      rd(2'd0, 2'd1, 24'h123456, "R2 addr0 readback");
      rd(2'd0, 2'd2, 24'h00BEEF, "R2 data0 readback");
      rd(2'd0, 2'd3, 24'h00FF00, "R2 mask0 readback");
      rd(2'd0, 2'd0, 24'h0000C1, "R2 ctrl0 readback");
      wr(2'd1, 2'd2, 24'h00AAAA);
      wr(2'd1, 2'd0, 24'h0000C1);
      rd(2'd1, 2'd2, '0, "R2 data1 write ignored");
      rd(2'd1, 2'd0, 24'h000001, "R2 ctrl1 mode bits read zero");
      disable_all();

      // R3 masked exact match on comparator 0
      wr(2'd0, 2'd0, 24'h01);
      bus(1'b0, 1'b1, 24'h123456, 16'hBE12, 1'b0, 1'b0, 4'b0001, "R3 low byte masked");
      bus(1'b0, 1'b1, 24'h123456, 16'hBF12, 1'b0, 1'b0, 4'b0000, "R3 masked bit differs");
      bus(1'b0, 1'b1, 24'h123457, 16'hBEEF, 1'b0, 1'b0, 4'b0000, "R3 address differs");

      // R4 / R5 address-only and disabled comparators
      disable_all();
      wr(2'd1, 2'd1, 24'h000100);
      wr(2'd3, 2'd1, 24'h000100);
      wr(2'd1, 2'd0, 24'h01);
      bus(1'b0, 1'b1, 24'h000100, 16'h1234, 1'b1, 1'b1, 4'b0010, "R4 R5 addr-only hit, disabled quiet");
      bus(1'b0, 1'b1, 24'h000100, 16'hFFFF, 1'b0, 1'b0, 4'b0010, "R4 any data");

      // R6 bus select
      disable_all();
      wr(2'd2, 2'd1, 24'h000200);
      wr(2'd2, 2'd0, 24'h03);
      bus(1'b1, 1'b1, 24'h000200, 16'h5555, 1'b0, 1'b0, 4'b0100, "R6 coprocessor bus hit");
      bus(1'b0, 1'b1, 24'h000200, 16'h5555, 1'b0, 1'b0, 4'b0000, "R6 CPU bus ignored");

      // R7 direction and size qualifiers
      disable_all();
      wr(2'd0, 2'd0, 24'h0D);
      bus(1'b0, 1'b1, 24'h123456, 16'hBE00, 1'b0, 1'b0, 4'b0000, "R7 write rejected");
      bus(1'b0, 1'b1, 24'h123456, 16'hBE00, 1'b1, 1'b0, 4'b0001, "R7 read accepted");
      wr(2'd0, 2'd0, 24'h31);
      bus(1'b0, 1'b1, 24'h123456, 16'hBE00, 1'b0, 1'b0, 4'b0000, "R7 byte rejected");
      bus(1'b0, 1'b1, 24'h123456, 16'hBE00, 1'b0, 1'b1, 4'b0001, "R7 word accepted");

      // R8 inside window, partner suppressed
      disable_all();
      wr(2'd0, 2'd1, 24'h001000);
      wr(2'd1, 2'd1, 24'h001FFF);
      wr(2'd1, 2'd0, 24'h01);
      bus(1'b0, 1'b1, 24'h001FFF, 16'h0, 1'b0, 1'b0, 4'b0010, "R8 partner exact before window");
      wr(2'd0, 2'd0, 24'h41);
      bus(1'b0, 1'b1, 24'h000FFF, 16'h0, 1'b0, 1'b0, 4'b0000, "R8 below min");
      bus(1'b0, 1'b1, 24'h001000, 16'h0, 1'b0, 1'b0, 4'b0001, "R8 on min");
      bus(1'b0, 1'b1, 24'h001FFF, 16'h0, 1'b0, 1'b0, 4'b0001, "R8 on max, partner quiet");
      bus(1'b0, 1'b1, 24'h002000, 16'h0, 1'b0, 1'b0, 4'b0000, "R8 above max");

      // R9 outside window
      wr(2'd0, 2'd0, 24'h81);
      bus(1'b0, 1'b1, 24'h000FFF, 16'h0, 1'b0, 1'b0, 4'b0001, "R9 below min");
      bus(1'b0, 1'b1, 24'h001000, 16'h0, 1'b0, 1'b0, 4'b0000, "R9 on min");
      bus(1'b0, 1'b1, 24'h001800, 16'h0, 1'b0, 1'b0, 4'b0000, "R9 inside");
      bus(1'b0, 1'b1, 24'h001FFF, 16'h0, 1'b0, 1'b0, 4'b0000, "R9 on max");
      bus(1'b0, 1'b1, 24'h002000, 16'h0, 1'b0, 1'b0, 4'b0001, "R9 above max");

      // R10 idle cycles and per-cycle pulses
      disable_all();
      wr(2'd1, 2'd1, 24'h000300);
      wr(2'd1, 2'd0, 24'h01);
      bus(1'b0, 1'b0, 24'h000300, 16'h0, 1'b0, 1'b0, 4'b0000, "R10 idle cycle");
      bus(1'b0, 1'b1, 24'h000300, 16'h0, 1'b0, 1'b0, 4'b0010, "R10 first pulse");
      bus(1'b0, 1'b1, 24'h000300, 16'h0, 1'b0, 1'b0, 4'b0010, "R10 second pulse");
      bus(1'b0, 1'b0, 24'h000300, 16'h0, 1'b0, 1'b0, 4'b0000, "R10 pulse ends");

      // R11 inhibit
      disable_all();
      wr(2'd0, 2'd1, 24'h000400);
      wr(2'd0, 2'd3, 24'h0);
      wr(2'd0, 2'd0, 24'h01);
      wr(2'd2, 2'd1, 24'h000400);
      wr(2'd2, 2'd0, 24'h03);
      cpu_inhibit = 1'b1;
      bus(1'b0, 1'b1, 24'h000400, 16'h0, 1'b0, 1'b0, 4'b0000, "R11 CPU comparator muted");
      bus(1'b1, 1'b1, 24'h000400, 16'h0, 1'b0, 1'b0, 4'b0100, "R11 coprocessor comparator live");
      wr(2'd1, 2'd1, 24'h000ABC);
      rd(2'd1, 2'd1, 24'h000ABC, "R11 register write under inhibit");
      cpu_inhibit = 1'b0;
      bus(1'b0, 1'b1, 24'h000400, 16'h0, 1'b0, 1'b0, 4'b0001, "R11 CPU comparator after release");

      @(negedge clk);
      idle_bus();
      repeat (3) @(posedge clk);
      #3;
      if (!finished) begin
         finished = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      #(8 * 200000);
      if (!finished) begin
         finished = 1'b1;
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule